// File: doc/BRIEF.md
# CPU Doze Clock Ratio Controller

This block throttles the CPU and program-memory clock while the rest of the chip keeps running at the full system clock. When doze is on, it raises a clock-enable pulse for one system clock out of every N. N is a power of two picked by a 3-bit ratio code. When doze is off, the enable is high on every cycle. Peripherals never see this enable, so their rate does not change.

The doze-enable state is a register that software writes. Hardware can also change it around interrupts. If the recover-on-interrupt control is set, an ISR-entry strobe turns doze off, so the service routine runs at full speed. If the doze-on-exit control is set, an ISR-exit strobe turns doze back on. The register's live value is an output, so the status that software reads always matches what the hardware has done.

The interrupt controller and the CPU are outside this block. They supply the entry and exit strobes and use the enable.

Top module: `cpu_doze_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the doze state clears. After that edge, `doze_en` reads 0 and `cpu_clk_en` reads 1.
- R2: While `doze_en` is 0, `cpu_clk_en` is 1 on every cycle.
- R3: While `doze_en` is 1 and the ratio code k stays stable, `cpu_clk_en` is 1 on exactly one cycle out of every 2^(k+1). Code 000 gives 1:2, code 001 gives 1:4 (one active cycle, then three idle), and code 111 gives 1:256.
- R4: The first cycle in which `doze_en` reads 1 after being 0 is an active cycle. The period count starts from that cycle on every enable.
- R5: A cycle with `sw_wr` high loads `sw_doze_val` into `doze_en` at the next edge. A software write takes priority over any ISR strobe in the same cycle.
- R6: When `isr_enter` and `roi_en` are both high and there is no software write, `doze_en` is 0 after the next edge. `cpu_clk_en` is high from that cycle on. Entry wins over an exit strobe in the same cycle.
- R7: An `isr_enter` strobe with `roi_en` low does not change `doze_en`, and the active-cycle pattern continues without a break.
- R8: When `isr_exit` and `doe_en` are both high, with no software write and no recovering entry, `doze_en` is 1 after the next edge, and that cycle is an active cycle.
- R9: An `isr_exit` strobe with `doe_en` low leaves `doze_en` unchanged.
- R10: A change of `ratio_sel` while dozing restarts the count. The cycle after the edge that sees the new code is active, and the new period follows from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ratio_sel | input | 3 | Ratio code k; the divide is 2^(k+1) |
| sw_wr | input | 1 | Software write strobe for the doze-enable bit |
| sw_doze_val | input | 1 | Value written by a software write |
| roi_en | input | 1 | Recover-on-interrupt control |
| doe_en | input | 1 | Doze-on-exit control |
| isr_enter | input | 1 | One-cycle strobe when an ISR is entered |
| isr_exit | input | 1 | One-cycle strobe when an ISR returns |
| cpu_clk_en | output | 1 | CPU and program-memory clock enable |
| doze_en | output | 1 | Live doze-enable state |

## Verification
The bench checks the enable cycle by cycle over several full periods at the smallest ratio, at the 1:4 ratio and at the 1:256 ratio. A counter that is off by one, or that uses the wrong encoding, would show up there as a shifted or stretched pulse. Each enable, whether from software or from ISR exit, is checked to give an active cycle at once. A design that kept a stale count from before would instead open with idle cycles. The bench also sends ISR strobes with their controls cleared, sends strobes in the same cycle as a software write, and changes the ratio in the middle of a period. A wrong priority would leave doze in the wrong state. A missing restart would give a truncated or merged period.

// File: rtl/doze_pkg.sv
// Shared types for the doze controller.
// Assumes: at most one enable event wins per cycle; the winner is found by a fixed priority.
package doze_pkg;

    // The event that decides the next doze-enable value
    typedef enum logic [2:0] {
        DZ_EV_NONE    = 3'd0,
        DZ_EV_SW_SET  = 3'd1,
        DZ_EV_SW_CLR  = 3'd2,
        DZ_EV_ISR_CLR = 3'd3,
        DZ_EV_ISR_SET = 3'd4
    } doze_event_e;

endpackage

// File: rtl/doze_ratio_decode.sv
// Registers the ratio code and turns it into a wrap mask for the phase counter.
// Code k gives a mask with bits 0..k set, so the period is 2^(k+1).
// Assumes: CNT_W >= 2**RATIO_W, so the largest code still fits.
module doze_ratio_decode #(
    parameter int RATIO_W = 3,
    parameter int CNT_W   = 1 << RATIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [CNT_W-1:0]   mask_o,
    output logic               changed_o
);

    logic [RATIO_W-1:0] ratio_q;

    // Hold the ratio code that the counter currently uses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= '0;
        end else begin
            ratio_q <= ratio_i;
        end
    end

    // A new code forces the counter to restart
    always_comb changed_o = (ratio_i != ratio_q);

    // Mask bit i is set when i <= code
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask_o[i] = (32'(ratio_q) >= i);
    end

endmodule

// File: rtl/doze_enable_ctrl.sv
// Holds the doze-enable bit. Software writes come first, then a recovering ISR
// entry, then a re-arming ISR exit.
// Assumes: the ISR strobes are one cycle wide and synchronous to clk.
module doze_enable_ctrl
    import doze_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_wr_i,
    input  logic sw_val_i,
    input  logic roi_i,
    input  logic doe_i,
    input  logic isr_enter_i,
    input  logic isr_exit_i,
    output logic doze_q_o
);

    doze_event_e ev;
    logic        doze_q;

    // Pick the single event that wins this cycle
    always_comb begin
        if (sw_wr_i)                   ev = sw_val_i ? DZ_EV_SW_SET : DZ_EV_SW_CLR;
        else if (isr_enter_i && roi_i) ev = DZ_EV_ISR_CLR;
        else if (isr_exit_i && doe_i)  ev = DZ_EV_ISR_SET;
        else                           ev = DZ_EV_NONE;
    end

    // Apply the winning event to the enable bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            doze_q <= 1'b0;
        end else begin
            case (ev)
                DZ_EV_SW_SET, DZ_EV_ISR_SET: doze_q <= 1'b1;
                DZ_EV_SW_CLR, DZ_EV_ISR_CLR: doze_q <= 1'b0;
                default:                     doze_q <= doze_q;
            endcase
        end
    end

    assign doze_q_o = doze_q;

    assert_sw_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_i |=> (doze_q == $past(sw_val_i)));

    assert_roi_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_enter_i && roi_i && !sw_wr_i) |=> !doze_q);

    assert_doe_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_exit_i && doe_i && !sw_wr_i && !(isr_enter_i && roi_i)) |=> doze_q);

    // R7 and R9: strobes without their control leave the bit alone
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_i && !(isr_enter_i && roi_i) && !(isr_exit_i && doe_i)) |=> $stable(doze_q));

endmodule

// File: rtl/doze_phase_counter.sv
// Counts system clocks within a doze period and flags phase zero as the active cycle.
// Held at zero while doze is off, so every enable starts on an active cycle.
// Assumes: the mask has its set bits packed at the bottom and changes only with restart_i.
module doze_phase_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] mask_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt_q;

    // Advance the phase and wrap at the mask; clear when idle or restarted
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q == mask_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb tick_o = (cnt_q == '0);

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i && cnt_q == mask_i) |=> (cnt_q == '0));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i && cnt_q != mask_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));

    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> tick_o);

endmodule

// File: rtl/cpu_doze_ctrl.sv
// Top of the doze controller. It gives the CPU one enabled clock out of every
// 2^(k+1) while doze is on, and an enable on every cycle while doze is off.
// Assumes: peripherals ignore cpu_clk_en and run on every clk.
module cpu_doze_ctrl #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_sel,
    input  logic               sw_wr,
    input  logic               sw_doze_val,
    input  logic               roi_en,
    input  logic               doe_en,
    input  logic               isr_enter,
    input  logic               isr_exit,
    output logic               cpu_clk_en,
    output logic               doze_en
);

    localparam int CNT_W = 1 << RATIO_W;

    logic             doze_q;
    logic [CNT_W-1:0] mask;
    logic             ratio_changed;
    logic             tick;

    doze_enable_ctrl u_enable (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_wr_i     (sw_wr),
        .sw_val_i    (sw_doze_val),
        .roi_i       (roi_en),
        .doe_i       (doe_en),
        .isr_enter_i (isr_enter),
        .isr_exit_i  (isr_exit),
        .doze_q_o    (doze_q)
    );

    doze_ratio_decode #(
        .RATIO_W (RATIO_W),
        .CNT_W   (CNT_W)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_i   (ratio_sel),
        .mask_o    (mask),
        .changed_o (ratio_changed)
    );

    doze_phase_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (doze_q),
        .restart_i (ratio_changed),
        .mask_i    (mask),
        .tick_o    (tick)
    );

    // Full rate when doze is off, otherwise only on phase zero
    always_comb cpu_clk_en = !doze_q || tick;

    assign doze_en = doze_q;

    assert_full_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !doze_en |-> cpu_clk_en);

    assert_first_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(doze_en) |-> cpu_clk_en);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!doze_en && cpu_clk_en));

endmodule

// File: tb/cpu_doze_ctrl_bench.sv
module cpu_doze_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ratio_sel = '0;
    logic       sw_wr = 1'b0;
    logic       sw_doze_val = 1'b0;
    logic       roi_en = 1'b0;
    logic       doe_en = 1'b0;
    logic       isr_enter = 1'b0;
    logic       isr_exit = 1'b0;
    logic       cpu_clk_en;
    logic       doze_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_doze_ctrl u_cpu_doze_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ratio_sel   (ratio_sel),
        .sw_wr       (sw_wr),
        .sw_doze_val (sw_doze_val),
        .roi_en      (roi_en),
        .doe_en      (doe_en),
        .isr_enter   (isr_enter),
        .isr_exit    (isr_exit),
        .cpu_clk_en  (cpu_clk_en),
        .doze_en     (doze_en)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock edge, then settle before sampling or driving
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic sw_write(input logic v);
        sw_wr = 1'b1;
        sw_doze_val = v;
        step();
        sw_wr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        step();
        check("R1 doze_en", doze_en, 1'b0);
        check("R1 cpu_clk_en", cpu_clk_en, 1'b1);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_off_full_rate();
        for (int c = 0; c < 20; c++) begin
            check("R2 enable while off", cpu_clk_en, 1'b1);
            step();
        end
    endtask

    // Enable at ratio k and check three full periods, then disable
    task automatic t_ratio(input int k);
        int n;
        n = 1 << (k + 1);
        ratio_sel = 3'(k);
        step();
        sw_write(1'b1);
        check("R5 sw set", doze_en, 1'b1);
        check("R4 first active", cpu_clk_en, 1'b1);
        for (int c = 0; c < 3 * n; c++) begin
            check("R3 ratio pattern", cpu_clk_en, ((c % n) == 0));
            step();
        end
        sw_write(1'b0);
        check("R5 sw clear", doze_en, 1'b0);
        check("R2 full rate after clear", cpu_clk_en, 1'b1);
    endtask

    task automatic t_isr_recover();
        ratio_sel = 3'd2;
        roi_en = 1'b1;
        doe_en = 1'b1;
        step();
        sw_write(1'b1);
        step();
        step();
        isr_enter = 1'b1;
        step();
        isr_enter = 1'b0;
        check("R6 roi clears", doze_en, 1'b0);
        check("R6 full rate", cpu_clk_en, 1'b1);
        step();
        check("R6 stays full rate", cpu_clk_en, 1'b1);
        isr_exit = 1'b1;
        step();
        isr_exit = 1'b0;
        check("R8 doe sets", doze_en, 1'b1);
        check("R8 active at re-enable", cpu_clk_en, 1'b1);
        for (int c = 1; c < 16; c++) begin
            step();
            check("R8 pattern after exit", cpu_clk_en, ((c % 8) == 0));
        end
        // entry and exit in the same cycle: entry wins
        isr_enter = 1'b1;
        isr_exit = 1'b1;
        step();
        isr_enter = 1'b0;
        isr_exit = 1'b0;
        check("R6 entry beats exit", doze_en, 1'b0);
        roi_en = 1'b0;
        doe_en = 1'b0;
    endtask

    task automatic t_strobes_ignored();
        int ph;
        ratio_sel = 3'd1;
        roi_en = 1'b0;
        step();
        sw_write(1'b1);
        ph = 0;
        for (int c = 0; c < 12; c++) begin
            isr_enter = (c == 2) || (c == 7);
            step();
            ph = (ph + 1) % 4;
            check("R7 doze kept", doze_en, 1'b1);
            check("R7 pattern kept", cpu_clk_en, (ph == 0));
        end
        isr_enter = 1'b0;
        sw_write(1'b0);
        doe_en = 1'b0;
        isr_exit = 1'b1;
        step();
        isr_exit = 1'b0;
        check("R9 exit without doe", doze_en, 1'b0);
        check("R9 full rate kept", cpu_clk_en, 1'b1);
    endtask

    task automatic t_priority();
        roi_en = 1'b1;
        isr_enter = 1'b1;
        sw_write(1'b1);
        isr_enter = 1'b0;
        check("R5 sw set beats roi", doze_en, 1'b1);
        doe_en = 1'b1;
        isr_exit = 1'b1;
        sw_write(1'b0);
        isr_exit = 1'b0;
        check("R5 sw clear beats doe", doze_en, 1'b0);
        roi_en = 1'b0;
        doe_en = 1'b0;
    endtask

    task automatic t_ratio_change();
        ratio_sel = 3'd2;
        step();
        sw_write(1'b1);
        step();
        step();
        step();
        check("R10 idle before change", cpu_clk_en, 1'b0);
        ratio_sel = 3'd1;
        step();
        check("R10 restart active", cpu_clk_en, 1'b1);
        for (int c = 1; c < 12; c++) begin
            step();
            check("R10 new period", cpu_clk_en, ((c % 4) == 0));
        end
        sw_write(1'b0);
    endtask

    initial begin
        t_reset();
        t_off_full_rate();
        t_ratio(0);
        t_ratio(1);
        t_ratio(2);
        t_ratio(7);
        t_isr_recover();
        t_strobes_ignored();
        t_priority();
        t_ratio_change();
        // reset while dozing returns to full rate (R1)
        sw_write(1'b1);
        step();
        t_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule